// File: doc/BRIEF.md
# Interleaved Quad Hamming Encoder

This block guards a 128-bit data word on its way into a buffer memory and restores it on the way out. On the write side the word is cut into four 32-bit lanes. Each lane becomes a 38-bit single-error-correcting Hamming codeword with six even-parity check bits. The four codewords are then woven together bit by bit into one 152-bit stored word. Bits that sit next to each other in storage therefore always belong to different lanes.

On the read side the stored word is un-woven and a six-bit syndrome is computed for each lane. A non-zero syndrome that names a real codeword position flips that bit back. A syndrome that points past the end of the codeword marks the lane as uncorrectable. Because of the weaving, any run of up to four adjacent upset bits lands in four different lanes and is fully repaired.

Encode and decode are independent paths. Each is one registered stage, with its valid signal carried alongside the data.

Top module: `iqh_codec`

## Requirements
- R1: While reset is asserted (rst_n low), every output is zero.
- R2: An output valid goes high on the clock edge after its input valid is seen high, and low on the edge after it is seen low. This applies to both the encode and decode stages, with exactly one cycle of latency.
- R3: Lane k carries data bits 32k+31 down to 32k of the 128-bit input, for k from 0 to 3.
- R4: Each codeword uses positions 1 to 38, where position p is codeword bit p-1. Check bits sit at positions 1, 2, 4, 8, 16 and 32. The 32 lane data bits fill the other positions in ascending order, lane bit 0 at position 3. Each check bit gives even parity over all positions whose index has that check bit's position bit set. For example, data value 1 encodes to stored word 0x111.
- R5: Codeword bit j of lane k is stored at word bit 4j+k.
- R6: Decoding an unaltered encoded word returns the original 128-bit data, with no lane flagged as corrected or uncorrectable.
- R7: A single flipped bit at any of the 152 stored positions is repaired. The corrected flag is set for lane (position mod 4) only, and no uncorrectable flag is raised.
- R8: Four adjacent flipped stored bits, starting at any offset from 0 to 148, are repaired, with all four corrected flags set.
- R9: A lane whose syndrome exceeds 38 raises its uncorrectable flag and not its corrected flag, and its data bits pass through unchanged. A lane never has both flags set at once.
- R10: While an input valid is low, the matching output data and flags hold their previous values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Encode input qualifier |
| enc_data_i | input | 128 | Data word to protect |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | 152 | Interleaved encoded word |
| dec_valid_i | input | 1 | Decode input qualifier |
| dec_word_i | input | 152 | Stored word read back from memory |
| dec_valid_o | output | 1 | Decoded data valid |
| dec_data_o | output | 128 | Repaired data word |
| dec_corrected_o | output | 4 | Per-lane flag: one bit was repaired |
| dec_uncorr_o | output | 4 | Per-lane flag: syndrome out of range |

## Verification
The hardest situation to reach is the out-of-range syndrome. No single error and no interleaved burst can produce it; it needs two errors in the same lane whose position indices combine to a value above 38. The bench encodes a word, then flips lane 2's codeword positions 7 and 32 (stored bits 26 and 126). This gives syndrome 39. The bench expects the uncorrectable flag on lane 2 alone, and expects lane data bit 3 to come out inverted because no repair is applied. The full sweeps of single-bit positions and four-bit burst offsets are reached by corrupting one clean encoded word in turn.

// File: rtl/iqh_pkg.sv
package iqh_pkg;

   // True when p is a power of two (a check-bit position).
   function automatic bit is_pow2(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // Data bit index held at non-check position p (1-based).
   function automatic int data_idx(int p);
      return p - 1 - $clog2(p + 1);
   endfunction

   // Positions 1..n whose index has bit i set, as a bit vector (bit p-1).
   function automatic logic [63:0] chk_mask(int i, int n);
      logic [63:0] m;
      m = '0;
      for (int p = 1; p <= n; p++) begin
         if (((p >> i) & 1) == 1) m[p-1] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/iqh_lane_enc.sv
module iqh_lane_enc
   import iqh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   localparam int CW_W  = DATA_W + CHK_W
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CW_W-1:0]   code_o
);

   initial begin
      assert (CHK_W == $clog2(CW_W + 1))
         else $error("iqh_lane_enc: CHK_W does not fit DATA_W");
      assert (CW_W <= 64)
         else $error("iqh_lane_enc: codeword wider than 64 bits");
   end

   // Codeword with check positions cleared; parity is taken over it.
   logic [CW_W-1:0] raw;

   for (genvar p = 1; p <= CW_W; p++) begin : g_pos
      if (is_pow2(p)) begin : g_chk
         localparam int              BIT  = $clog2(p);
         localparam logic [CW_W-1:0] MASK = CW_W'(chk_mask(BIT, CW_W));
         assign raw[p-1]    = 1'b0;
         assign code_o[p-1] = ^(raw & MASK);
      end else begin : g_dat
         assign raw[p-1]    = data_i[data_idx(p)];
         assign code_o[p-1] = raw[p-1];
      end
   end

endmodule

// File: rtl/iqh_lane_dec.sv
module iqh_lane_dec
   import iqh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   localparam int CW_W  = DATA_W + CHK_W
) (
   input  logic [CW_W-1:0]   code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              unc_o
);

   initial begin
      assert (CHK_W == $clog2(CW_W + 1))
         else $error("iqh_lane_dec: CHK_W does not fit DATA_W");
      assert (CW_W <= 64)
         else $error("iqh_lane_dec: codeword wider than 64 bits");
   end

   logic [CHK_W-1:0] syn;
   logic [CW_W-1:0]  flip;
   logic             in_range;

   for (genvar i = 0; i < CHK_W; i++) begin : g_syn
      localparam logic [CW_W-1:0] MASK = CW_W'(chk_mask(i, CW_W));
      assign syn[i] = ^(code_i & MASK);
   end

   assign in_range = (syn != '0) && (syn <= CHK_W'(CW_W));

   always_comb begin
      flip = '0;
      if (in_range) flip[syn - CHK_W'(1)] = 1'b1;
   end

   assign corr_o = |flip;
   assign unc_o  = (syn > CHK_W'(CW_W));

   for (genvar p = 1; p <= CW_W; p++) begin : g_ext
      if (!is_pow2(p)) begin : g_dat
         assign data_o[data_idx(p)] = code_i[p-1] ^ flip[p-1];
      end
   end

endmodule

// File: rtl/iqh_pipe_reg.sv
module iqh_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);

   initial begin
      assert (W > 0) else $error("iqh_pipe_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) data_o <= data_i;
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o); // R2
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(data_o)); // R10

endmodule

// File: rtl/iqh_codec.sv
module iqh_codec
   import iqh_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   parameter int CHK_W  = 6,
   localparam int CW_W   = LANE_W + CHK_W,
   localparam int DATA_W = LANES * LANE_W,
   localparam int WORD_W = LANES * CW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_valid_i,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic              enc_valid_o,
   output logic [WORD_W-1:0] enc_word_o,
   input  logic              dec_valid_i,
   input  logic [WORD_W-1:0] dec_word_i,
   output logic              dec_valid_o,
   output logic [DATA_W-1:0] dec_data_o,
   output logic [LANES-1:0]  dec_corrected_o,
   output logic [LANES-1:0]  dec_uncorr_o
);

   initial begin
      assert (LANES >= 1) else $error("iqh_codec: LANES must be at least 1");
   end

   // ---------------- encode path ----------------
   logic [CW_W-1:0]   enc_cw [LANES];
   logic [WORD_W-1:0] enc_word_c;

   for (genvar k = 0; k < LANES; k++) begin : g_enc
      iqh_lane_enc #(.DATA_W(LANE_W), .CHK_W(CHK_W)) u_enc (
         .data_i (enc_data_i[k*LANE_W +: LANE_W]),
         .code_o (enc_cw[k])
      );
      for (genvar j = 0; j < CW_W; j++) begin : g_ilv
         assign enc_word_c[LANES*j + k] = enc_cw[k][j];
      end
   end

   iqh_pipe_reg #(.W(WORD_W)) u_enc_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (enc_valid_i),
      .data_i  (enc_word_c),
      .valid_o (enc_valid_o),
      .data_o  (enc_word_o)
   );

   // ---------------- decode path ----------------
   logic [CW_W-1:0]   dec_cw [LANES];
   logic [DATA_W-1:0] dec_data_c;
   logic [LANES-1:0]  dec_corr_c;
   logic [LANES-1:0]  dec_unc_c;

   for (genvar k = 0; k < LANES; k++) begin : g_dec
      for (genvar j = 0; j < CW_W; j++) begin : g_dil
         assign dec_cw[k][j] = dec_word_i[LANES*j + k];
      end
      iqh_lane_dec #(.DATA_W(LANE_W), .CHK_W(CHK_W)) u_dec (
         .code_i (dec_cw[k]),
         .data_o (dec_data_c[k*LANE_W +: LANE_W]),
         .corr_o (dec_corr_c[k]),
         .unc_o  (dec_unc_c[k])
      );
   end

   iqh_pipe_reg #(.W(DATA_W + 2*LANES)) u_dec_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (dec_valid_i),
      .data_i  ({dec_unc_c, dec_corr_c, dec_data_c}),
      .valid_o (dec_valid_o),
      .data_o  ({dec_uncorr_o, dec_corrected_o, dec_data_o})
   );

   // ---------------- checking logic ----------------
   // Independent decode of the registered encoder output.
   logic [CW_W-1:0]   chk_cw [LANES];
   logic [DATA_W-1:0] chk_data;
   logic [LANES-1:0]  chk_corr;
   logic [LANES-1:0]  chk_unc;

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      for (genvar j = 0; j < CW_W; j++) begin : g_dil
         assign chk_cw[k][j] = enc_word_o[LANES*j + k];
      end
      iqh_lane_dec #(.DATA_W(LANE_W), .CHK_W(CHK_W)) u_chk (
         .code_i (chk_cw[k]),
         .data_o (chk_data[k*LANE_W +: LANE_W]),
         .corr_o (chk_corr[k]),
         .unc_o  (chk_unc[k])
      );
   end

   AST_ENC_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_o |-> (chk_corr == '0) && (chk_unc == '0)
                      && (chk_data == $past(enc_data_i))); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_corrected_o & dec_uncorr_o) == '0); // R9

endmodule

// File: tb/iqh_codec_test.sv
`timescale 1ns/1ps
module iqh_codec_test;

   logic         clk;
   logic         rst_n;
   logic         enc_valid_i;
   logic [127:0] enc_data_i;
   logic         enc_valid_o;
   logic [151:0] enc_word_o;
   logic         dec_valid_i;
   logic [151:0] dec_word_i;
   logic         dec_valid_o;
   logic [127:0] dec_data_o;
   logic [3:0]   dec_corrected_o;
   logic [3:0]   dec_uncorr_o;

   int n_chk  = 0;
   int n_fail = 0;

   iqh_codec uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .enc_valid_i     (enc_valid_i),
      .enc_data_i      (enc_data_i),
      .enc_valid_o     (enc_valid_o),
      .enc_word_o      (enc_word_o),
      .dec_valid_i     (dec_valid_i),
      .dec_word_i      (dec_word_i),
      .dec_valid_o     (dec_valid_o),
      .dec_data_o      (dec_data_o),
      .dec_corrected_o (dec_corrected_o),
      .dec_uncorr_o    (dec_uncorr_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(string req, string what, logic [151:0] act, logic [151:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Encoder model written from the requirements.
   function automatic logic [151:0] model_enc(logic [127:0] d);
      logic [151:0] w;
      w = '0;
      for (int k = 0; k < 4; k++) begin
         logic [37:0] cw;
         int di;
         cw = '0;
         di = 0;
         for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
               cw[p-1] = d[32*k + di];
               di++;
            end
         end
         for (int i = 0; i < 6; i++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 38; p++)
               if (((p >> i) & 1) == 1) par ^= cw[p-1];
            cw[(1 << i) - 1] = par;
         end
         for (int j = 0; j < 38; j++) w[4*j + k] = cw[j];
      end
      return w;
   endfunction

   function automatic logic [127:0] next_pat(logic [127:0] s);
      logic [127:0] x;
      x = s;
      x ^= x << 13;
      x ^= x >> 7;
      x ^= x << 17;
      return x;
   endfunction

   task automatic do_enc(logic [127:0] d, output logic [151:0] w);
      @(negedge clk);
      enc_valid_i = 1'b1;
      enc_data_i  = d;
      @(negedge clk);
      enc_valid_i = 1'b0;
      w = enc_word_o;
   endtask

   task automatic do_dec(logic [151:0] w);
      @(negedge clk);
      dec_valid_i = 1'b1;
      dec_word_i  = w;
      @(negedge clk);
      dec_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      enc_valid_i = 1'b1; enc_data_i = '1;
      dec_valid_i = 1'b1; dec_word_i = '1;
      repeat (3) @(negedge clk);
      chk("R1", "enc_valid_o", enc_valid_o, 0);
      chk("R1", "enc_word_o", enc_word_o, 0);
      chk("R1", "dec_valid_o", dec_valid_o, 0);
      chk("R1", "dec_data_o", dec_data_o, 0);
      chk("R1", "flags", {dec_uncorr_o, dec_corrected_o}, 0);
      enc_valid_i = 1'b0; enc_data_i = '0;
      dec_valid_i = 1'b0; dec_word_i = '0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_latency();
      logic [127:0] d;
      d = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
      @(negedge clk);
      enc_valid_i = 1'b1; enc_data_i = d;
      dec_valid_i = 1'b1; dec_word_i = model_enc(d);
      chk("R2", "enc_valid_o before edge", enc_valid_o, 0);
      chk("R2", "dec_valid_o before edge", dec_valid_o, 0);
      @(negedge clk);
      chk("R2", "enc_valid_o after edge", enc_valid_o, 1);
      chk("R2", "dec_valid_o after edge", dec_valid_o, 1);
      chk("R2", "enc_word_o after edge", enc_word_o, model_enc(d));
      chk("R2", "dec_data_o after edge", dec_data_o, d);
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
      @(negedge clk);
      chk("R2", "enc_valid_o drop", enc_valid_o, 0);
      chk("R2", "dec_valid_o drop", dec_valid_o, 0);
   endtask

   task automatic t_format();
      logic [151:0] w;
      logic [127:0] d;
      do_enc(128'h1, w);
      chk("R4", "data 1 layout", w, 152'h111);
      do_enc(128'h1 << 32, w);
      chk("R3", "lane1 bit0 layout", w, 152'h222);
      do_enc(128'h1 << 127, w);
      chk("R5", "lane3 bit31 layout", w, model_enc(128'h1 << 127));
      d = 128'hdead_beef_cafe_f00d_1234_5678_9abc_def0;
      for (int n = 0; n < 6; n++) begin
         do_enc(d, w);
         chk("R4", "codeword vs model", w, model_enc(d));
         d = next_pat(d);
      end
   endtask

   task automatic t_roundtrip();
      logic [151:0] w;
      logic [127:0] pats [4];
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = {32{4'ha}};
      pats[3] = 128'h8000_0001_7fff_fffe_0f0f_f0f0_3c3c_c3c3;
      for (int n = 0; n < 4; n++) begin
         do_enc(pats[n], w);
         do_dec(w);
         chk("R6", "clean data", dec_data_o, pats[n]);
         chk("R6", "clean flags", {dec_uncorr_o, dec_corrected_o}, 0);
      end
   endtask

   task automatic t_single();
      logic [151:0] w;
      logic [127:0] d;
      d = 128'h5a5a_0ff0_1357_9bdf_2468_ace0_c001_d00d;
      do_enc(d, w);
      for (int pos = 0; pos < 152; pos++) begin
         do_dec(w ^ (152'h1 << pos));
         chk("R7", $sformatf("data pos %0d", pos), dec_data_o, d);
         chk("R7", $sformatf("corr pos %0d", pos), dec_corrected_o, 4'h1 << (pos % 4));
         chk("R7", $sformatf("unc pos %0d", pos), dec_uncorr_o, 0);
      end
   endtask

   task automatic t_burst();
      logic [151:0] w;
      logic [127:0] d;
      d = 128'hfeed_face_0bad_c0de_7777_1111_abcd_ef01;
      do_enc(d, w);
      for (int off = 0; off <= 148; off++) begin
         do_dec(w ^ (152'hf << off));
         chk("R8", $sformatf("data off %0d", off), dec_data_o, d);
         chk("R8", $sformatf("corr off %0d", off), dec_corrected_o, 4'hf);
         chk("R8", $sformatf("unc off %0d", off), dec_uncorr_o, 0);
      end
   endtask

   task automatic t_uncorr();
      logic [151:0] w;
      logic [127:0] d;
      d = 128'h0000_ffff_0000_ffff_aaaa_5555_aaaa_5555;
      do_enc(d, w);
      // lane 2 positions 7 and 32 -> syndrome 39
      do_dec(w ^ (152'h1 << 26) ^ (152'h1 << 126));
      chk("R9", "unc flag", dec_uncorr_o, 4'b0100);
      chk("R9", "corr flag", dec_corrected_o, 0);
      chk("R9", "data passthrough", dec_data_o, d ^ (128'h1 << 67));
   endtask

   task automatic t_hold();
      logic [151:0] w, w_hold;
      logic [127:0] d;
      d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
      do_enc(d, w);
      do_dec(w ^ (152'h1 << 26) ^ (152'h1 << 126));
      @(negedge clk);
      enc_data_i = ~d;
      dec_word_i = '0;
      w_hold = w;
      repeat (2) @(negedge clk);
      chk("R10", "enc word held", enc_word_o, w_hold);
      chk("R10", "dec data held", dec_data_o, d ^ (128'h1 << 67));
      chk("R10", "dec flags held", {dec_uncorr_o, dec_corrected_o}, 8'h40);
   endtask

   initial begin
      #(20ns * 50000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_format();
      t_roundtrip();
      t_single();
      t_burst();
      t_uncorr();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule